// File: doc/BRIEF.md
# Approximate 4-2 Partial-Product Compressor

This cell folds four partial-product bits of one column into two output bits, a carry and a sum. The carry has twice the weight of the sum. It trades exactness for a very shallow logic cone. There is no carry-in and no carry-out, so no ripple runs between neighbouring columns. It is meant for the low-order columns of an approximate multiplier's reduction tree, where small count errors matter little.

A build-time parameter picks the variant:

- **Plain:** the sum is a four-input OR.
- **Compensated:** a correction bit is XORed onto the sum. The correction fires only when each input pair, (x1, x2) and (x3, x4), holds exactly one '1'. Those four patterns are the ones the plain form over-counts.

The cell is purely combinational, with no clock and no storage.

Input bit `pp_i[0]` is x1, `pp_i[1]` is x2, `pp_i[2]` is x3 and `pp_i[3]` is x4. Patterns below are written x4x3x2x1.

Top module: `apx42_cell`

## Requirements
- R1: In both modes `carry_o` equals (x1 OR x2) AND (x3 OR x4).
- R2: With COMP_EN=0, `sum_o` is the OR of all four inputs, so it is 0 only for pattern 0000. In both modes carry and sum are both 0 exactly when the input is 0000.
- R3: With COMP_EN=1, the patterns 0101, 0110, 1001 and 1010 give `sum_o`=0. Their value 2*carry+sum then equals the true count of ones, which is 2.
- R4: With COMP_EN=1, for the other twelve patterns `sum_o` equals the plain-mode sum.
- R5: The error distance is (2*carry+sum) minus the count of ones in the input. In plain mode it is +1 for 0101, 0110, 1001 and 1010. It is -1 for 0011, 1100 and 1111, and 0 for all other patterns. In compensated mode it is -1 for 0011, 1100 and 1111 and 0 for all others.
- R6: Each pattern with k ones has weight 3^(4-k) (out of 256). The weighted sum of absolute error distances over all 16 patterns is 55 in plain mode and 19 in compensated mode, so compensation lowers it.
- R7: The outputs depend only on the present input, never on the order in which patterns were applied. Walking the patterns in reverse order gives the same outputs as walking them forward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pp_i | input | 4 | Column partial-product bits; bit 0 is x1, bit 3 is x4 |
| carry_o | output | 1 | Carry, weight 2 |
| sum_o | output | 1 | Sum, weight 1 |

## Verification
The hardest behaviour to reach is the boundary of the correction term. It must fire on exactly the four patterns with one '1' in each pair. It must stay silent on the two patterns where one pair is full and the other empty (0011 and 1100), which look alike by count. A plain sweep could mask a wrongly widened correction if only counts were compared. So every one of the 16 patterns is applied to a plain and a compensated instance side by side. Each output bit is compared, and the signed error distance and its weighted total are recomputed per mode. The sweep is then repeated in reverse order to expose any hidden dependence on earlier inputs.

// File: rtl/apx42_cell.sv
`timescale 1ns/1ps
module apx42_cell #(
  parameter bit COMP_EN = 1'b0
) (
  input  logic [3:0] pp_i,
  output logic       carry_o,
  output logic       sum_o
);

  logic lo_any, hi_any;
  logic sum_raw;

  assign lo_any  = pp_i[0] | pp_i[1];
  assign hi_any  = pp_i[2] | pp_i[3];
  assign carry_o = lo_any & hi_any;
  assign sum_raw = lo_any | hi_any;

  generate
    if (COMP_EN) begin : g_comp
      logic fix;
      assign fix   = (pp_i[0] ^ pp_i[1]) & (pp_i[2] ^ pp_i[3]);
      assign sum_o = sum_raw ^ fix;
    end else begin : g_plain
      assign sum_o = sum_raw;
    end
  endgenerate

endmodule

// File: rtl/apx42_cell_chk.sv
`timescale 1ns/1ps
module apx42_cell_chk #(
  parameter bit COMP_EN = 1'b0
) (
  input logic [3:0] pp_i,
  input logic       carry_o,
  input logic       sum_o
);

  int ones;
  int total;

  always_comb begin
    ones  = $countones(pp_i);
    total = 2 * int'(carry_o) + int'(sum_o);
    if (!$isunknown({pp_i, carry_o, sum_o})) begin
      // R1: a carry needs at least two ones present
      p_carry_pairs_r1: assert (!carry_o || ones >= 2)
        else $error("carry without two ones");
      // R2: outputs both zero exactly for the empty column
      p_zero_only_r2: assert ((carry_o | sum_o) == (pp_i != 4'b0000))
        else $error("zero output mismatch");
      // R5: error distance never exceeds one
      p_ed_bound_r5: assert (total - ones <= 1 && ones - total <= 1)
        else $error("error distance beyond one");
      // R3: one-per-pair patterns are exact when compensated
      p_pair_exact_r3: assert (!(COMP_EN && $countones(pp_i[1:0]) == 1
                                && $countones(pp_i[3:2]) == 1) || total == 2)
        else $error("compensated pattern not exact");
      // R4: compensated form never over-counts
      p_no_over_r4: assert (!COMP_EN || total <= ones)
        else $error("compensated over-count");
    end
  end

endmodule

bind apx42_cell apx42_cell_chk #(.COMP_EN(COMP_EN)) u_chk (
  .pp_i(pp_i),
  .carry_o(carry_o),
  .sum_o(sum_o)
);

// File: tb/apx42_cell_tb.sv
`timescale 1ns/1ps
module apx42_cell_tb;

  // per pattern: [3]=carry plain [2]=sum plain [1]=carry comp [0]=sum comp
  localparam logic [3:0] EXP [16] = '{
    4'b0000, 4'b0101, 4'b0101, 4'b0101,
    4'b0101, 4'b1110, 4'b1110, 4'b1111,
    4'b0101, 4'b1110, 4'b1110, 4'b1111,
    4'b0101, 4'b1111, 4'b1111, 4'b1111
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] pp = 4'b0000;
  logic c_pl, s_pl, c_ec, s_ec;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  apx42_cell #(.COMP_EN(1'b0)) u_dut    (.pp_i(pp), .carry_o(c_pl), .sum_o(s_pl));
  apx42_cell #(.COMP_EN(1'b1)) u_dut_ec (.pp_i(pp), .carry_o(c_ec), .sum_o(s_ec));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] v);
    @(posedge clk);
    pp = v;
    @(negedge clk);
  endtask

  function automatic int wgt(input logic [3:0] v);
    int w = 1;
    for (int k = 0; k < 4 - $countones(v); k++) w = w * 3;
    return w;
  endfunction

  function automatic int expected_ed(input logic [3:0] v, input bit comp);
    if (v == 4'b0011 || v == 4'b1100 || v == 4'b1111) return -1;
    if (!comp && (v == 4'b0101 || v == 4'b0110 || v == 4'b1001 || v == 4'b1010)) return 1;
    return 0;
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] fwd_pl [16];
    logic [3:0] fwd_ec [16];
    int wsum_pl = 0;
    int wsum_ec = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({c_pl, s_pl, c_ec, s_ec} == 4'b0000, "R2 idle", {c_pl, s_pl, c_ec, s_ec}, 0);

    for (int i = 0; i < 16; i++) begin
      logic [3:0] v;
      int ed_pl, ed_ec, cnt;
      v = 4'(i);
      apply(v);
      cnt = $countones(v);
      chk(c_pl == EXP[i][3], $sformatf("R1 plain carry p%0d", i), c_pl, EXP[i][3]);
      chk(c_ec == EXP[i][1], $sformatf("R1 comp carry p%0d", i), c_ec, EXP[i][1]);
      chk(s_pl == EXP[i][2], $sformatf("R2 plain sum p%0d", i), s_pl, EXP[i][2]);
      if (v == 4'b0101 || v == 4'b0110 || v == 4'b1001 || v == 4'b1010)
        chk(s_ec == 1'b0, $sformatf("R3 comp sum p%0d", i), s_ec, 0);
      else
        chk(s_ec == EXP[i][2], $sformatf("R4 comp sum p%0d", i), s_ec, EXP[i][2]);
      ed_pl = 2 * int'(c_pl) + int'(s_pl) - cnt;
      ed_ec = 2 * int'(c_ec) + int'(s_ec) - cnt;
      chk(ed_pl == expected_ed(v, 1'b0), $sformatf("R5 plain ed p%0d", i), ed_pl, expected_ed(v, 1'b0));
      chk(ed_ec == expected_ed(v, 1'b1), $sformatf("R5 comp ed p%0d", i), ed_ec, expected_ed(v, 1'b1));
      wsum_pl += wgt(v) * (ed_pl < 0 ? -ed_pl : ed_pl);
      wsum_ec += wgt(v) * (ed_ec < 0 ? -ed_ec : ed_ec);
      fwd_pl[i] = {2'b00, c_pl, s_pl};
      fwd_ec[i] = {2'b00, c_ec, s_ec};
    end

    chk(wsum_pl == 55, "R6 plain weighted", wsum_pl, 55);
    chk(wsum_ec == 19, "R6 comp weighted", wsum_ec, 19);
    chk(wsum_ec < wsum_pl, "R6 comp lower", wsum_ec, wsum_pl);

    for (int i = 15; i >= 0; i--) begin
      apply(4'(i));
      chk({c_pl, s_pl} == fwd_pl[i][1:0], $sformatf("R7 plain reverse p%0d", i), {c_pl, s_pl}, fwd_pl[i][1:0]);
      chk({c_ec, s_ec} == fwd_ec[i][1:0], $sformatf("R7 comp reverse p%0d", i), {c_ec, s_ec}, fwd_ec[i][1:0]);
    end

    // corner: jump from full column to empty, then to each lone-pair pattern
    apply(4'b1111);
    apply(4'b0000);
    chk({c_pl, s_pl, c_ec, s_ec} == 4'b0000, "R2 full to empty", {c_pl, s_pl, c_ec, s_ec}, 0);
    apply(4'b0011);
    chk({c_ec, s_ec} == 2'b01, "R4 pair 0011 untouched", {c_ec, s_ec}, 1);
    apply(4'b1100);
    chk({c_ec, s_ec} == 2'b01, "R4 pair 1100 untouched", {c_ec, s_ec}, 1);
    apply(4'b1001);
    chk({c_ec, s_ec} == 2'b10, "R3 cross 1001", {c_ec, s_ec}, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule